// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock, serial data) into parallel left and right samples. All three serial wires are brought into the system clock domain through a two-flop synchronizer. A bit is taken on each detected rising edge of the bit clock. A small framing state machine then decides which of the sampled bits form the word of each channel.

A 4-bit format field selects one of four framing conventions and one of three word lengths at run time. The conventions are: MSB aligned to the frame-clock change; MSB one bit late; LSB aligned to the end of the half-frame; and a short-pulse mode that carries the two channels back to back. Every word arrives MSB first in two's complement. The block sign-extends each word to a 24-bit output and marks it with a one-cycle strobe for its channel.

The framing state machine has four states:

- **HUNT**: after reset, waiting for the first frame marker.
- **LAG**: skipping one bit after a marker, in the delayed modes.
- **WORD**: shifting in word bits.
- **GAP**: ignoring padding until the next marker.

The transitions are:

- **marker→WORD**: aligned-start mode.
- **marker→LAG**: delayed and pulse modes.
- **marker→GAP**: end-aligned mode, which emits the word that has just finished.
- **LAG→WORD**: on the next bit.
- **WORD→WORD**: in pulse mode, when the left word completes and the right word follows.
- **WORD→GAP**: when the word length is reached.

A frame marker from any state restarts framing.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both sample outputs read zero and both strobes are low.
- R2: Format field bits [1:0] = 00 (aligned start). The MSB is the bit sampled on the first rising bit-clock edge at which the frame clock shows its new level. The word sampled while the frame clock is high is the left sample.
- R3: Format field bits [1:0] = 01 (delayed start). The MSB is the bit sampled one bit-clock after the edge where the frame-clock change is first seen. The word sampled while the frame clock is low is the left sample.
- R4: Format field bits [1:0] = 10 (end aligned). The word consists of the last N bits sampled before the frame clock changes level. It belongs to the left channel if the frame clock was high during that half-frame.
- R5: Format field bits [1:0] = 11 (pulse framing). A rising frame clock marks the frame start. The left MSB follows one bit later, and the right word starts on the bit right after the left LSB.
- R6: Format field bits [3:2] select the word length N: 00 gives 24, 01 gives 20, 10 gives 16, and 11 is treated as 24.
- R7: Words are taken MSB first as two's complement, and each output is the word sign-extended to 24 bits.
- R8: Each strobe is high for exactly one system clock per word. The two strobes are never high together. A sample output changes only in a cycle where its strobe is high.
- R9: Bits of a half-frame that lie outside the N-bit word do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk_in | input | 1 | Asynchronous serial bit clock |
| frame_in | input | 1 | Asynchronous frame (left/right) clock |
| sdata_in | input | 1 | Asynchronous serial data |
| fmt_sel | input | 4 | Framing in [1:0], word length in [3:2] |
| left_data | output | 24 | Sign-extended left sample |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Sign-extended right sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
The assertions watch the output handshake on every cycle:

- Each strobe lasts a single cycle.
- The two strobes never coincide.
- Samples hold steady between strobes.
- The upper bits of a 16-bit or 20-bit result copy its sign bit.

Which bits land in which channel can only be shown by the bench's scenarios. These cover each framing mode at every word length, random half-frame widths and junk padding, and extreme signed values, all compared against words the bench encodes itself.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    localparam int OUT_W = 24;
    localparam int CNT_W = $clog2(OUT_W + 1);

    typedef enum logic [1:0] {
        FMT_ALIGN = 2'b00,
        FMT_DELAY = 2'b01,
        FMT_TAIL  = 2'b10,
        FMT_PULSE = 2'b11
    } frame_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LAG,
        ST_WORD,
        ST_GAP
    } rx_state_e;

    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        unique case (code)
            2'b01:   word_bits = CNT_W'(20);
            2'b10:   word_bits = CNT_W'(16);
            default: word_bits = CNT_W'(24);
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] sign_fill(input logic [OUT_W-1:0] w,
                                                   input logic [1:0] code);
        unique case (code)
            2'b01:   sign_fill = {{4{w[19]}}, w[19:0]};
            2'b10:   sign_fill = {{8{w[15]}}, w[15:0]};
            default: sign_fill = w;
        endcase
    endfunction
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sarx_fsm.sv
module sarx_fsm
    import sarx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             lr_bit,
    input  logic             sd_bit,
    input  logic [3:0]       fmt_sel,
    output logic [OUT_W-1:0] left_data,
    output logic             left_valid,
    output logic [OUT_W-1:0] right_data,
    output logic             right_valid
);
    rx_state_e        state_q, state_d;
    logic             chan_left_q, chan_left_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [OUT_W-1:0] shreg_q, shreg_d;
    logic             lr_prev_q, lr_prev_d;

    frame_mode_e      mode;
    logic [CNT_W-1:0] nbits;
    logic [OUT_W-1:0] sh_in;
    logic             marker;
    logic             new_left;
    logic             emit;
    logic             emit_left;
    logic [OUT_W-1:0] emit_word;

    assign mode  = frame_mode_e'(fmt_sel[1:0]);
    assign nbits = word_bits(fmt_sel[3:2]);
    assign sh_in = {shreg_q[OUT_W-2:0], sd_bit};

    always_comb begin
        marker   = (mode == FMT_PULSE) ? (lr_bit & ~lr_prev_q) : (lr_bit ^ lr_prev_q);
        new_left = (mode == FMT_DELAY) ? ~lr_bit : ((mode == FMT_PULSE) ? 1'b1 : lr_bit);
    end

    // next-state logic
    always_comb begin
        state_d     = state_q;
        chan_left_d = chan_left_q;
        cnt_d       = cnt_q;
        shreg_d     = shreg_q;
        lr_prev_d   = lr_prev_q;
        emit        = 1'b0;
        emit_left   = chan_left_q;
        emit_word   = sh_in;
        if (bit_tick) begin
            lr_prev_d = lr_bit;
            shreg_d   = sh_in;
            if (marker) begin
                chan_left_d = new_left;
                if (mode == FMT_TAIL) begin
                    if (state_q != ST_HUNT) begin
                        emit      = 1'b1;
                        emit_word = shreg_q;
                    end
                    state_d = ST_GAP;
                end else if (mode == FMT_ALIGN) begin
                    cnt_d   = CNT_W'(1);
                    state_d = ST_WORD;
                end else begin
                    cnt_d   = '0;
                    state_d = ST_LAG;
                end
            end else begin
                unique case (state_q)
                    ST_HUNT: state_d = ST_HUNT;
                    ST_LAG: begin
                        cnt_d   = CNT_W'(1);
                        state_d = ST_WORD;
                    end
                    ST_WORD: begin
                        if (cnt_q + CNT_W'(1) == nbits) begin
                            emit = 1'b1;
                            if (mode == FMT_PULSE && chan_left_q) begin
                                chan_left_d = 1'b0;
                                cnt_d       = '0;
                            end else begin
                                state_d = ST_GAP;
                            end
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                    ST_GAP: state_d = ST_GAP;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_HUNT;
            chan_left_q <= 1'b1;
            cnt_q       <= '0;
            shreg_q     <= '0;
            lr_prev_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            chan_left_q <= chan_left_d;
            cnt_q       <= cnt_d;
            shreg_q     <= shreg_d;
            lr_prev_q   <= lr_prev_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_data   <= '0;
            left_valid  <= 1'b0;
            right_data  <= '0;
            right_valid <= 1'b0;
        end else begin
            left_valid  <= emit & emit_left;
            right_valid <= emit & ~emit_left;
            if (emit & emit_left)  left_data  <= sign_fill(emit_word, fmt_sel[3:2]);
            if (emit & ~emit_left) right_data <= sign_fill(emit_word, fmt_sel[3:2]);
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             frame_in,
    input  logic             sdata_in,
    input  logic [3:0]       fmt_sel,
    output logic [OUT_W-1:0] left_data,
    output logic             left_valid,
    output logic [OUT_W-1:0] right_data,
    output logic             right_valid
);
    logic [2:0] wires_sync;
    logic       bclk_last;
    logic       bit_tick;

    sarx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({bclk_in, frame_in, sdata_in}),
        .q_sync (wires_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_last <= 1'b0;
        else        bclk_last <= wires_sync[2];
    end

    assign bit_tick = wires_sync[2] & ~bclk_last;

    sarx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .lr_bit     (wires_sync[1]),
        .sd_bit     (wires_sync[0]),
        .fmt_sel    (fmt_sel),
        .left_data  (left_data),
        .left_valid (left_valid),
        .right_data (right_data),
        .right_valid(right_valid)
    );
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  fmt_sel,
    input logic [23:0] left_data,
    input logic        left_valid,
    input logic [23:0] right_data,
    input logic        right_valid
);
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(left_valid && right_valid)); // R8
    AST_LEFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) left_valid |=> !left_valid); // R8
    AST_RIGHT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) right_valid |=> !right_valid); // R8
    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !left_valid |-> $stable(left_data)); // R8
    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !right_valid |-> $stable(right_data)); // R8
    AST_LEFT_SIGN16: assert property (@(posedge clk) disable iff (!rst_n) (left_valid && $past(fmt_sel[3:2]) == 2'b10) |-> (left_data[23:15] == 9'h000 || left_data[23:15] == 9'h1FF)); // R7
    AST_RIGHT_SIGN20: assert property (@(posedge clk) disable iff (!rst_n) (right_valid && $past(fmt_sel[3:2]) == 2'b01) |-> (right_data[23:19] == 5'h00 || right_data[23:19] == 5'h1F)); // R7
endmodule

bind serial_audio_rx sarx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .left_data  (left_data),
    .left_valid (left_valid),
    .right_data (right_data),
    .right_valid(right_valid)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdat = 1'b0;
    logic [3:0]  fmt = 4'h0;
    logic [23:0] left_data, right_data;
    logic        left_valid, right_valid;

    int          n_checks = 0;
    int          n_fail = 0;
    string       tag = "R1";
    logic [23:0] exp_q[$];
    bit          expl_q[$];

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .frame_in(lrclk), .sdata_in(sdat),
        .fmt_sel(fmt), .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] sx(input logic [23:0] v, input int n);
        logic [23:0] hi = 24'hFFFFFF << n;
        return (v & ~hi) | (v[n-1] ? hi : 24'h0);
    endfunction

    always @(negedge clk) begin
        logic [23:0] e, got;
        bit el;
        if (rst_n) begin
            if (left_valid && right_valid) chk(1'b0, "R8 both strobes high", 24'h1, 24'h0);
            if (left_valid || right_valid) begin
                got = left_valid ? left_data : right_data;
                if (exp_q.size() == 0) begin
                    chk(1'b0, {tag, " unexpected word"}, got, 24'h0);
                end else begin
                    e  = exp_q.pop_front();
                    el = expl_q.pop_front();
                    chk(left_valid == el && got == e, {tag, el ? " left" : " right"}, got, e);
                end
            end
        end
    end

    task automatic send_bit(input logic l, input logic d);
        bclk = 1'b0; lrclk = l; sdat = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic rbit();
        return 1'($urandom & 1);
    endfunction

    // R9: padding bits are random junk
    task automatic send_half(input logic l, input logic [23:0] w, input int n, input int mode);
        int slot = n + 2 + int'($urandom % (31 - n));
        for (int i = 0; i < slot; i++) begin
            logic b;
            case (mode)
                0:       b = (i < n) ? w[n-1-i] : rbit();
                1:       b = (i >= 1 && i <= n) ? w[n-i] : rbit();
                default: b = (i >= slot - n) ? w[slot-1-i] : rbit();
            endcase
            send_bit(l, b);
        end
    endtask

    task automatic run_cfg(input int mode, input int lcode, input int frames, input string t);
        int n = (lcode == 1) ? 20 : ((lcode == 2) ? 16 : 24);
        logic leftlvl = (mode == 1) ? 1'b0 : 1'b1;
        logic [23:0] mask = ~(24'hFFFFFF << n);
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; lrclk = (mode == 1); sdat = 1'b0;
        fmt = {2'(lcode), 2'(mode)};
        tag = t;
        exp_q.delete(); expl_q.delete();
        repeat (4) @(negedge clk);
        chk(left_data == 24'h0 && !left_valid, "R1 reset left", left_data, 24'h0);
        chk(right_data == 24'h0 && !right_valid, "R1 reset right", right_data, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(left_data == 24'h0 && right_data == 24'h0 && !left_valid && !right_valid,
            "R1 first cycle after reset", left_data | right_data, 24'h0);
        for (int k = 0; k < 4; k++) send_bit(mode == 1, 1'b0);
        for (int f = 0; f < frames; f++) begin
            logic [23:0] lw = 24'($urandom) & mask;
            logic [23:0] rw = 24'($urandom) & mask;
            if (f == 0) begin  // R7 extremes
                lw = 24'h1 << (n - 1);
                rw = (24'h1 << (n - 1)) - 24'h1;
            end else if (f == 1) begin
                lw = mask;
                rw = 24'h0;
            end
            exp_q.push_back(sx(lw, n)); expl_q.push_back(1'b1);
            exp_q.push_back(sx(rw, n)); expl_q.push_back(1'b0);
            if (mode == 3) begin
                send_bit(1'b1, rbit());
                for (int i = 0; i < n; i++) send_bit(1'b0, lw[n-1-i]);
                for (int i = 0; i < n; i++) send_bit(1'b0, rw[n-1-i]);
                for (int i = 0; i < int'($urandom % 4); i++) send_bit(1'b0, rbit());
            end else begin
                send_half(leftlvl, lw, n, mode);
                send_half(~leftlvl, rw, n, mode);
            end
        end
        for (int k = 0; k < 3; k++) send_bit((mode == 3) ? 1'b0 : leftlvl, (mode == 3) ? 1'b0 : rbit());
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, {t, " R6 all words delivered"}, 24'(exp_q.size()), 24'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 4; m++) begin
            for (int lc = 0; lc < 3; lc++) begin
                case (m)
                    0:       run_cfg(m, lc, 6, "R2 R6 R7 R9");
                    1:       run_cfg(m, lc, 6, "R3 R6 R7 R9");
                    2:       run_cfg(m, lc, 6, "R4 R6 R7 R9");
                    default: run_cfg(m, lc, 6, "R5 R6 R7");
                endcase
            end
        end
        run_cfg(0, 3, 4, "R6 code 11 as 24 R2");
        run_cfg(2, 3, 4, "R6 code 11 as 24 R4");
        finish_run();
    end
endmodule